// File: doc/BRIEF.md
# Card Host Status and Interrupt Register File

This block is the software-visible register file of a memory-card host controller. It decodes a word-addressed request port and holds the configuration words for card power, clock control, command argument, command word, data timeout, data length and data control. It presents the result of a command and the data transfer state that a separate data engine drives through its ports. The command and data-control writes are handed to the engine as one-cycle strobes.

Status is 22 bits wide. The low 11 bits are sticky event flags that the engine sets and software clears by writing ones to a clear register. The upper 11 bits follow live level inputs. Two interrupt lines each OR together the status bits that their own mask enables. A 16-word aliased window passes FIFO words between software and the engine. A byte-count register also reads back as a rounded-up word count. Eight identification bytes sit at the top of the 4 KiB space. Any access that matches no register, or that goes the wrong way for it, raises a bad-address strobe and has no effect.

Reads are combinational: `rdata_o` is valid in the cycle the request is presented. Writes take effect at the clock edge that ends the request cycle.

Top module: `sdh_csr_regs`

## Requirements
- R1: After reset every writable register, both masks and all sticky status bits read zero, and both interrupt lines are low.
- R2: Power (0x00), clock control (0x04) and data control (0x2C) keep only wdata[7:0]. Data length (0x28) keeps wdata[15:0]. Each mask keeps wdata[21:0]. Argument (0x08), command (0x0C) and data timer (0x24) keep all 32 bits. Every one of them reads back what it kept, zero-extended.
- R3: A write to 0x0C makes `cmd_wr_o` high for exactly the next cycle, with `cmd_o` already holding the written word. A write to 0x2C does the same on `data_ctrl_wr_o`.
- R4: Status at 0x34 reads {stat_live_i[10:0], sticky[10:0]}. A bit pulsed on stat_set_i sets the matching sticky bit, and that bit stays set until it is cleared.
- R5: A write to 0x38 clears exactly the sticky bits whose positions are one in wdata[10:0]. wdata[31:11] has no effect. If a bit is set on stat_set_i in the same cycle, the set wins.
- R6: irq_o[i] is high exactly when status AND mask i is nonzero. Mask 0 is at 0x3C and mask 1 is at 0x40.
- R7: 0x30 reads data_cnt_i. 0x48 reads (data_cnt_i + 3) >> 2.
- R8: A write to any word offset from 0x80 to 0xBC pulses fifo_wr_o with fifo_wdata_o = wdata when data_cnt_i is nonzero. When data_cnt_i is zero the write is dropped.
- R9: A read of any word offset from 0x80 to 0xBC returns fifo_rdata_i and pulses fifo_rd_o when fifo_empty_i is low. When fifo_empty_i is high it returns 0, does not pulse fifo_rd_o, and pulses fifo_underrun_o.
- R10: Reads of 0xFE0, 0xFE4 … 0xFFC return 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order.
- R11: An access to an unmapped or non-word-aligned offset, a write to a read-only register, or a read of the clear register raises bad_addr_o in that cycle. Such an access reads 0 and changes no state.
- R12: 0x10 reads resp_cmd_i. 0x14, 0x18, 0x1C and 0x20 read response words 0 to 3, taken from resp_i[32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| bad_addr_o | output | 1 | Illegal access strobe |
| power_o | output | 8 | Power control word |
| clk_div_o | output | 8 | Clock control word |
| cmd_arg_o | output | 32 | Command argument |
| cmd_o | output | 32 | Command word |
| cmd_wr_o | output | 1 | Command written strobe |
| data_timer_o | output | 32 | Data timeout |
| data_len_o | output | 16 | Data length in bytes |
| data_ctrl_o | output | 8 | Data control word |
| data_ctrl_wr_o | output | 1 | Data control written strobe |
| resp_cmd_i | input | 6 | Responding command index |
| resp_i | input | 128 | Four response words |
| data_cnt_i | input | 16 | Remaining byte count |
| stat_set_i | input | 11 | Sticky status set pulses |
| stat_live_i | input | 11 | Live status levels |
| irq_o | output | 2 | Masked interrupt lines |
| fifo_wr_o | output | 1 | FIFO push strobe |
| fifo_wdata_o | output | 32 | FIFO push word |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| fifo_rdata_i | input | 32 | FIFO head word |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_underrun_o | output | 1 | Read of empty FIFO strobe |

## Verification
The hardest case to reach is a clear write and a set pulse that land on the same sticky bit in the same cycle. Software alone can never line the two up. The bench drives the set input and the clear write in one cycle and checks that the bit survives. It also checks that untouched bits survive and that the live upper field ignores an all-ones clear. Random sequences mix set pulses, clears, mask writes and live changes, and after each step both interrupt lines are compared against a model.

// File: rtl/sdh_csr_pkg.sv
package sdh_csr_pkg;

  localparam int unsigned OFF_POWER  = 'h000;
  localparam int unsigned OFF_CLK    = 'h004;
  localparam int unsigned OFF_ARG    = 'h008;
  localparam int unsigned OFF_CMD    = 'h00C;
  localparam int unsigned OFF_RCMD   = 'h010;
  localparam int unsigned OFF_RESP   = 'h014;
  localparam int unsigned N_RESP     = 4;
  localparam int unsigned OFF_DTIMER = 'h024;
  localparam int unsigned OFF_DLEN   = 'h028;
  localparam int unsigned OFF_DCTRL  = 'h02C;
  localparam int unsigned OFF_DCNT   = 'h030;
  localparam int unsigned OFF_STAT   = 'h034;
  localparam int unsigned OFF_CLR    = 'h038;
  localparam int unsigned OFF_MASK   = 'h03C;
  localparam int unsigned OFF_FCNT   = 'h048;
  localparam int unsigned OFF_FIFO   = 'h080;
  localparam int unsigned OFF_ID     = 'hFE0;
  localparam int unsigned N_ID       = 8;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_POWER, SEL_CLK, SEL_ARG, SEL_CMD, SEL_RCMD, SEL_RESP,
    SEL_DTIMER, SEL_DLEN, SEL_DCTRL, SEL_DCNT, SEL_STAT, SEL_CLR,
    SEL_MASK, SEL_FCNT, SEL_FIFO, SEL_ID
  } sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/sdh_csr_decode.sv
module sdh_csr_decode
  import sdh_csr_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned N_IRQ      = 2,
  parameter int unsigned FIFO_WORDS = 16
) (
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o,
  output logic [2:0]    sub_o,
  output logic          rd_ok_o,
  output logic          wr_ok_o
);

  localparam int unsigned RESP_END = OFF_RESP + 4 * N_RESP;
  localparam int unsigned MASK_END = OFF_MASK + 4 * N_IRQ;
  localparam int unsigned FIFO_END = OFF_FIFO + 4 * FIFO_WORDS;
  localparam int unsigned ID_END   = OFF_ID + 4 * N_ID;

  logic [AW-1:0] d_resp, d_mask, d_id;
  assign d_resp = addr_i - AW'(OFF_RESP);
  assign d_mask = addr_i - AW'(OFF_MASK);
  assign d_id   = addr_i - AW'(OFF_ID);

  always_comb begin
    sel_o = SEL_NONE;
    sub_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      if      (addr_i == AW'(OFF_POWER))  sel_o = SEL_POWER;
      else if (addr_i == AW'(OFF_CLK))    sel_o = SEL_CLK;
      else if (addr_i == AW'(OFF_ARG))    sel_o = SEL_ARG;
      else if (addr_i == AW'(OFF_CMD))    sel_o = SEL_CMD;
      else if (addr_i == AW'(OFF_RCMD))   sel_o = SEL_RCMD;
      else if (addr_i >= AW'(OFF_RESP) && addr_i < AW'(RESP_END)) begin
        sel_o = SEL_RESP;
        sub_o = d_resp[4:2];
      end
      else if (addr_i == AW'(OFF_DTIMER)) sel_o = SEL_DTIMER;
      else if (addr_i == AW'(OFF_DLEN))   sel_o = SEL_DLEN;
      else if (addr_i == AW'(OFF_DCTRL))  sel_o = SEL_DCTRL;
      else if (addr_i == AW'(OFF_DCNT))   sel_o = SEL_DCNT;
      else if (addr_i == AW'(OFF_STAT))   sel_o = SEL_STAT;
      else if (addr_i == AW'(OFF_CLR))    sel_o = SEL_CLR;
      else if (addr_i >= AW'(OFF_MASK) && addr_i < AW'(MASK_END)) begin
        sel_o = SEL_MASK;
        sub_o = d_mask[4:2];
      end
      else if (addr_i == AW'(OFF_FCNT))   sel_o = SEL_FCNT;
      else if (addr_i >= AW'(OFF_FIFO) && addr_i < AW'(FIFO_END)) sel_o = SEL_FIFO;
      else if (addr_i >= AW'(OFF_ID) && {1'b0, addr_i} < (AW+1)'(ID_END)) begin
        sel_o = SEL_ID;
        sub_o = d_id[4:2];
      end
    end
  end

  always_comb begin
    rd_ok_o = (sel_o != SEL_NONE) && (sel_o != SEL_CLR);
    case (sel_o)
      SEL_POWER, SEL_CLK, SEL_ARG, SEL_CMD, SEL_DTIMER, SEL_DLEN,
      SEL_DCTRL, SEL_CLR, SEL_MASK, SEL_FIFO: wr_ok_o = 1'b1;
      default:                                wr_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdh_csr_status.sv
module sdh_csr_status #(
  parameter int unsigned STAT_W   = 22,
  parameter int unsigned STICKY_W = 11,
  parameter int unsigned N_IRQ    = 2,
  localparam int unsigned LIVE_W  = STAT_W - STICKY_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [STICKY_W-1:0]     set_i,
  input  logic [LIVE_W-1:0]       live_i,
  input  logic                    clr_we_i,
  input  logic [STICKY_W-1:0]     clr_mask_i,
  input  logic [N_IRQ-1:0]        mask_we_i,
  input  logic [STAT_W-1:0]       mask_wdata_i,
  output logic [STAT_W-1:0]       status_o,
  output logic [N_IRQ*STAT_W-1:0] mask_o,
  output logic [N_IRQ-1:0]        irq_o
);

  logic [STICKY_W-1:0] sticky_q;

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sticky_q <= '0;
    else if (clr_we_i) sticky_q <= (sticky_q & ~clr_mask_i) | set_i;
    else               sticky_q <= sticky_q | set_i;
  end

  assign status_o = {live_i, sticky_q};

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    logic [STAT_W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_q <= '0;
      else if (mask_we_i[g]) mask_q <= mask_wdata_i;
    end
    assign mask_o[g*STAT_W +: STAT_W] = mask_q;
    assign irq_o[g] = |(status_o & mask_q);

    assert_irq_masked_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_we_i[g] && mask_wdata_i == '0) |=> !irq_o[g]);
  end

  assert_clear_takes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((sticky_q & $past(clr_mask_i & ~set_i)) == '0));

  assert_sticky_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

endmodule

// File: rtl/sdh_csr_fifo_win.sv
module sdh_csr_fifo_win #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] data_cnt_i,
  input  logic             fifo_empty_i,
  input  logic [DW-1:0]    fifo_rdata_i,
  output logic             fifo_wr_o,
  output logic [DW-1:0]    fifo_wdata_o,
  output logic             fifo_rd_o,
  output logic             underrun_o,
  output logic [DW-1:0]    rdata_o
);

  assign fifo_wr_o    = hit_i && we_i && (data_cnt_i != '0);
  assign fifo_wdata_o = wdata_i;
  assign fifo_rd_o    = hit_i && !we_i && !fifo_empty_i;
  assign underrun_o   = hit_i && !we_i && fifo_empty_i;
  assign rdata_o      = fifo_rd_o ? fifo_rdata_i : '0;

  assert_push_needs_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> data_cnt_i != '0);
  assert_pop_needs_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);
  assert_underrun_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (rdata_o == '0 && !fifo_rd_o));

endmodule

// File: rtl/sdh_csr_regs.sv
module sdh_csr_regs
  import sdh_csr_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned STAT_W     = 22,
  parameter int unsigned STICKY_W   = 11,
  parameter int unsigned N_IRQ      = 2,
  parameter int unsigned FIFO_WORDS = 16,
  parameter int unsigned CTRL_W     = 8,
  parameter int unsigned RCMD_W     = 6,
  localparam int unsigned LIVE_W    = STAT_W - STICKY_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 bad_addr_o,
  output logic [CTRL_W-1:0]    power_o,
  output logic [CTRL_W-1:0]    clk_div_o,
  output logic [DW-1:0]        cmd_arg_o,
  output logic [DW-1:0]        cmd_o,
  output logic                 cmd_wr_o,
  output logic [DW-1:0]        data_timer_o,
  output logic [CNT_W-1:0]     data_len_o,
  output logic [CTRL_W-1:0]    data_ctrl_o,
  output logic                 data_ctrl_wr_o,
  input  logic [RCMD_W-1:0]    resp_cmd_i,
  input  logic [N_RESP*DW-1:0] resp_i,
  input  logic [CNT_W-1:0]     data_cnt_i,
  input  logic [STICKY_W-1:0]  stat_set_i,
  input  logic [LIVE_W-1:0]    stat_live_i,
  output logic [N_IRQ-1:0]     irq_o,
  output logic                 fifo_wr_o,
  output logic [DW-1:0]        fifo_wdata_o,
  output logic                 fifo_rd_o,
  input  logic [DW-1:0]        fifo_rdata_i,
  input  logic                 fifo_empty_i,
  output logic                 fifo_underrun_o
);

  sel_e       sel;
  logic [2:0] sub;
  logic       rd_ok, wr_ok, wr_en, rd_en;

  sdh_csr_decode #(.AW(AW), .N_IRQ(N_IRQ), .FIFO_WORDS(FIFO_WORDS)) u_dec (
    .addr_i(addr_i), .sel_o(sel), .sub_o(sub), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
  );

  assign wr_en      = req_i && we_i && wr_ok;
  assign rd_en      = req_i && !we_i && rd_ok;
  assign bad_addr_o = req_i && (we_i ? !wr_ok : !rd_ok);

  // configuration words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      power_o        <= '0;
      clk_div_o      <= '0;
      cmd_arg_o      <= '0;
      cmd_o          <= '0;
      data_timer_o   <= '0;
      data_len_o     <= '0;
      data_ctrl_o    <= '0;
      cmd_wr_o       <= 1'b0;
      data_ctrl_wr_o <= 1'b0;
    end else begin
      cmd_wr_o       <= wr_en && (sel == SEL_CMD);
      data_ctrl_wr_o <= wr_en && (sel == SEL_DCTRL);
      if (wr_en) begin
        case (sel)
          SEL_POWER:  power_o      <= wdata_i[CTRL_W-1:0];
          SEL_CLK:    clk_div_o    <= wdata_i[CTRL_W-1:0];
          SEL_ARG:    cmd_arg_o    <= wdata_i;
          SEL_CMD:    cmd_o        <= wdata_i;
          SEL_DTIMER: data_timer_o <= wdata_i;
          SEL_DLEN:   data_len_o   <= wdata_i[CNT_W-1:0];
          SEL_DCTRL:  data_ctrl_o  <= wdata_i[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // status and interrupts
  logic [STAT_W-1:0]       status;
  logic [N_IRQ*STAT_W-1:0] masks;
  logic [N_IRQ-1:0]        mask_we;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_mwe
    assign mask_we[g] = wr_en && (sel == SEL_MASK) && (sub == 3'(g));
  end

  sdh_csr_status #(.STAT_W(STAT_W), .STICKY_W(STICKY_W), .N_IRQ(N_IRQ)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(stat_set_i), .live_i(stat_live_i),
    .clr_we_i(wr_en && (sel == SEL_CLR)), .clr_mask_i(wdata_i[STICKY_W-1:0]),
    .mask_we_i(mask_we), .mask_wdata_i(wdata_i[STAT_W-1:0]),
    .status_o(status), .mask_o(masks), .irq_o(irq_o)
  );

  // FIFO window
  logic [DW-1:0] fifo_rdata;
  sdh_csr_fifo_win #(.DW(DW), .CNT_W(CNT_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(req_i && (sel == SEL_FIFO)), .we_i(we_i), .wdata_i(wdata_i),
    .data_cnt_i(data_cnt_i), .fifo_empty_i(fifo_empty_i), .fifo_rdata_i(fifo_rdata_i),
    .fifo_wr_o(fifo_wr_o), .fifo_wdata_o(fifo_wdata_o), .fifo_rd_o(fifo_rd_o),
    .underrun_o(fifo_underrun_o), .rdata_o(fifo_rdata)
  );

  // rounded-up word count
  logic [CNT_W:0] words_left;
  assign words_left = ({1'b0, data_cnt_i} + (CNT_W+1)'(3)) >> 2;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (sel)
        SEL_POWER:  rdata_o = DW'(power_o);
        SEL_CLK:    rdata_o = DW'(clk_div_o);
        SEL_ARG:    rdata_o = cmd_arg_o;
        SEL_CMD:    rdata_o = cmd_o;
        SEL_RCMD:   rdata_o = DW'(resp_cmd_i);
        SEL_RESP:   rdata_o = resp_i[sub[1:0]*DW +: DW];
        SEL_DTIMER: rdata_o = data_timer_o;
        SEL_DLEN:   rdata_o = DW'(data_len_o);
        SEL_DCTRL:  rdata_o = DW'(data_ctrl_o);
        SEL_DCNT:   rdata_o = DW'(data_cnt_i);
        SEL_STAT:   rdata_o = DW'(status);
        SEL_MASK:   rdata_o = DW'(masks[sub*STAT_W +: STAT_W]);
        SEL_FCNT:   rdata_o = DW'(words_left);
        SEL_FIFO:   rdata_o = fifo_rdata;
        SEL_ID:     rdata_o = DW'(id_byte(sub));
        default:    rdata_o = '0;
      endcase
    end
  end

  assert_bad_no_fifo_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> (!fifo_wr_o && !fifo_rd_o && rdata_o == '0));
  assert_bad_no_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |=> (!cmd_wr_o && !data_ctrl_wr_o && $stable(power_o) && $stable(clk_div_o)
                    && $stable(cmd_arg_o) && $stable(data_len_o) && $stable(data_ctrl_o)));
  assert_cmd_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_o |-> (cmd_o == $past(wdata_i)));
  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ctrl_wr_o |=> !data_ctrl_wr_o || $past(wr_en && sel == SEL_DCTRL));

endmodule

// File: tb/sdh_csr_regs_test.sv
module sdh_csr_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bad;
  logic [7:0]  power, clkdiv, dctrl;
  logic [31:0] arg, cmd, dtimer;
  logic [15:0] dlen;
  logic        cmd_wr, dctrl_wr;
  logic [5:0]  resp_cmd = 6'h2A;
  logic [127:0] resp = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
  logic [15:0] data_cnt = '0;
  logic [10:0] set_v = '0, live_v = '0;
  logic [1:0]  irq;
  logic        fwr, frd, fund, fempty = 1'b1;
  logic [31:0] fwdata, frdata = '0;

  int nchk = 0, nfail = 0;
  logic done = 1'b0;

  logic [31:0] cap_rdata, cap_fwd;
  logic        cap_bad, cap_fwr, cap_frd, cap_und;

  logic [31:0] m_reg [7];
  logic [10:0] m_sticky = '0;
  logic [21:0] m_mask [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_csr_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .bad_addr_o(bad), .power_o(power), .clk_div_o(clkdiv),
    .cmd_arg_o(arg), .cmd_o(cmd), .cmd_wr_o(cmd_wr), .data_timer_o(dtimer),
    .data_len_o(dlen), .data_ctrl_o(dctrl), .data_ctrl_wr_o(dctrl_wr),
    .resp_cmd_i(resp_cmd), .resp_i(resp), .data_cnt_i(data_cnt),
    .stat_set_i(set_v), .stat_live_i(live_v), .irq_o(irq),
    .fifo_wr_o(fwr), .fifo_wdata_o(fwdata), .fifo_rd_o(frd),
    .fifo_rdata_i(frdata), .fifo_empty_i(fempty), .fifo_underrun_o(fund)
  );

  localparam logic [11:0] CFG_OFF [7] = '{12'h000, 12'h004, 12'h008, 12'h00C,
                                          12'h024, 12'h028, 12'h02C};

  function automatic logic [31:0] keep_bits(input int idx, input logic [31:0] d);
    case (idx)
      0, 1, 6: keep_bits = {24'h0, d[7:0]};
      5:       keep_bits = {16'h0, d[15:0]};
      default: keep_bits = d;
    endcase
  endfunction

  function automatic logic [31:0] exp_status();
    exp_status = {10'h0, live_v, m_sticky};
  endfunction

  function automatic logic exp_irq(input int i);
    exp_irq = |(exp_status() & {10'h0, m_mask[i]});
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    cap_rdata = rdata; cap_bad = bad; cap_fwr = fwr; cap_fwd = fwdata;
    cap_frd = frd; cap_und = fund;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    access(1'b0, a, 32'h0);
    chk(tag, cap_rdata, exp);
  endtask

  task automatic pulse_set(input logic [10:0] b);
    @(negedge clk);
    set_v = b;
    @(posedge clk);
    #1;
    set_v = '0;
    m_sticky |= b;
  endtask

  task automatic chk_irqs(input string tag);
    chk({tag, " irq0"}, {31'h0, irq[0]}, {31'h0, exp_irq(0)});
    chk({tag, " irq1"}, {31'h0, irq[1]}, {31'h0, exp_irq(1)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 7; i++) m_reg[i] = '0;
    m_mask[0] = '0; m_mask[1] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 7; i++) rd_chk("R1 cfg reset", CFG_OFF[i], 32'h0);
    rd_chk("R1 status reset", 12'h034, 32'h0);
    rd_chk("R1 mask0 reset", 12'h03C, 32'h0);
    rd_chk("R1 mask1 reset", 12'h040, 32'h0);
    chk("R1 irq reset", {30'h0, irq}, 32'h0);

    // R2: width masking, all ones
    for (int i = 0; i < 7; i++) begin
      access(1'b1, CFG_OFF[i], 32'hFFFF_FFFF);
      m_reg[i] = keep_bits(i, 32'hFFFF_FFFF);
      rd_chk("R2 width", CFG_OFF[i], m_reg[i]);
    end
    access(1'b1, 12'h040, 32'hFFFF_FFFF);
    m_mask[1] = 22'h3F_FFFF;
    rd_chk("R2 mask width", 12'h040, 32'h003F_FFFF);
    access(1'b1, 12'h040, 32'h0);
    m_mask[1] = '0;

    // R3: command and data-control strobes
    access(1'b1, 12'h00C, 32'h1234_5678);
    m_reg[3] = 32'h1234_5678;
    chk("R3 cmd strobe", {31'h0, cmd_wr}, 32'h1);
    chk("R3 cmd value", cmd, 32'h1234_5678);
    @(posedge clk); #1;
    chk("R3 cmd strobe one cycle", {31'h0, cmd_wr}, 32'h0);
    access(1'b1, 12'h02C, 32'h0000_01A5);
    m_reg[6] = 32'hA5;
    chk("R3 dctrl strobe", {31'h0, dctrl_wr}, 32'h1);
    chk("R3 dctrl value", {24'h0, dctrl}, 32'hA5);
    @(posedge clk); #1;
    chk("R3 dctrl strobe one cycle", {31'h0, dctrl_wr}, 32'h0);

    // R4: sticky set and live field
    pulse_set(11'h009);
    live_v = 11'h401;
    rd_chk("R4 sticky and live", 12'h034, exp_status());
    @(posedge clk); #1;
    rd_chk("R4 sticky holds", 12'h034, exp_status());

    // R5: partial clear, upper bits ignored, set wins
    access(1'b1, 12'h038, 32'hFFFF_F801);
    m_sticky &= ~11'h001;
    rd_chk("R5 partial clear", 12'h034, exp_status());
    @(negedge clk);
    set_v = 11'h008; req = 1'b1; we = 1'b1; addr = 12'h038; wdata = 32'h0000_0008;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; set_v = '0;
    rd_chk("R5 set beats clear", 12'h034, exp_status());
    access(1'b1, 12'h038, 32'hFFFF_FFFF);
    m_sticky = '0;
    rd_chk("R5 clear all keeps live", 12'h034, exp_status());

    // R6: interrupt masks
    access(1'b1, 12'h03C, 32'h0000_0400);
    m_mask[0] = 22'h000400;
    live_v = '0;
    #1 chk_irqs("R6 live bit masked off");
    live_v = 11'h001;
    #1 chk_irqs("R6 live bit enabled");
    live_v = '0;

    // R7: data count and word count
    foreach (CFG_OFF[k]) begin end
    data_cnt = 16'd0;  rd_chk("R7 words 0", 12'h048, 32'd0);
    data_cnt = 16'd1;  rd_chk("R7 words 1", 12'h048, 32'd1);
    data_cnt = 16'd4;  rd_chk("R7 words 4", 12'h048, 32'd1);
    data_cnt = 16'd5;  rd_chk("R7 words 5", 12'h048, 32'd2);
    data_cnt = 16'hFFFF; rd_chk("R7 words max", 12'h048, 32'h4000);
    rd_chk("R7 byte count", 12'h030, 32'h0000_FFFF);

    // R8: FIFO window writes
    data_cnt = 16'd12;
    access(1'b1, 12'h080, 32'hCAFE_0001);
    chk("R8 push low", {31'h0, cap_fwr}, 32'h1);
    chk("R8 push data", cap_fwd, 32'hCAFE_0001);
    access(1'b1, 12'h0BC, 32'hCAFE_0002);
    chk("R8 push alias top", {31'h0, cap_fwr}, 32'h1);
    data_cnt = 16'd0;
    access(1'b1, 12'h0A0, 32'hCAFE_0003);
    chk("R8 push dropped", {31'h0, cap_fwr}, 32'h0);
    access(1'b1, 12'h0C0, 32'hCAFE_0004);
    chk("R8 past window is bad", {31'h0, cap_bad}, 32'h1);

    // R9: FIFO window reads
    fempty = 1'b0; frdata = 32'h5A5A_0FF0;
    access(1'b0, 12'h090, 32'h0);
    chk("R9 pop data", cap_rdata, 32'h5A5A_0FF0);
    chk("R9 pop strobe", {31'h0, cap_frd}, 32'h1);
    chk("R9 no underrun", {31'h0, cap_und}, 32'h0);
    fempty = 1'b1;
    access(1'b0, 12'h0B4, 32'h0);
    chk("R9 empty data", cap_rdata, 32'h0);
    chk("R9 empty no pop", {31'h0, cap_frd}, 32'h0);
    chk("R9 underrun", {31'h0, cap_und}, 32'h1);

    // R10: identification bytes
    begin
      logic [7:0] ids [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++)
        rd_chk("R10 id", 12'hFE0 + 12'(4 * i), {24'h0, ids[i]});
    end

    // R12: response readback
    rd_chk("R12 resp cmd", 12'h010, 32'h2A);
    for (int i = 0; i < 4; i++)
      rd_chk("R12 resp word", 12'h014 + 12'(4 * i), resp[32*i +: 32]);

    // R11: illegal accesses
    access(1'b0, 12'h044, 32'h0);
    chk("R11 unmapped read bad", {31'h0, cap_bad}, 32'h1);
    chk("R11 unmapped read zero", cap_rdata, 32'h0);
    access(1'b0, 12'h038, 32'h0);
    chk("R11 clear read bad", {31'h0, cap_bad}, 32'h1);
    access(1'b1, 12'h001, 32'h0000_0011);
    chk("R11 unaligned write bad", {31'h0, cap_bad}, 32'h1);
    rd_chk("R11 power unchanged", 12'h000, m_reg[0]);
    access(1'b1, 12'h034, 32'hFFFF_FFFF);
    chk("R11 status write bad", {31'h0, cap_bad}, 32'h1);
    access(1'b1, 12'h010, 32'h0);
    chk("R11 resp write bad", {31'h0, cap_bad}, 32'h1);
    access(1'b1, 12'h00E, 32'hDEAD_BEEF);
    chk("R11 no cmd strobe", {31'h0, cmd_wr}, 32'h0);
    rd_chk("R11 cmd unchanged", 12'h00C, m_reg[3]);

    // random mix: R2, R4, R5, R6
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: begin
          int i;
          logic [31:0] d;
          i = int'($urandom % 7);
          d = $urandom;
          access(1'b1, CFG_OFF[i], d);
          m_reg[i] = keep_bits(i, d);
          rd_chk("R2 random cfg", CFG_OFF[i], m_reg[i]);
        end
        1: pulse_set(11'($urandom) & 11'($urandom));
        2: begin
          logic [31:0] d;
          d = $urandom;
          access(1'b1, 12'h038, d);
          m_sticky &= ~d[10:0];
        end
        3: begin
          int i;
          logic [31:0] d;
          i = int'($urandom % 2);
          d = $urandom & $urandom;
          access(1'b1, 12'h03C + 12'(4 * i), d);
          m_mask[i] = d[21:0];
        end
        4: begin
          @(negedge clk);
          live_v = 11'($urandom) & 11'($urandom) & 11'($urandom);
        end
        default: rd_chk("R4 R5 random status", 12'h034, exp_status());
      endcase
      #1 chk_irqs("R6 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule